// File: doc/BRIEF.md
# Windowed FIFO Write Controller

This block is the write-side controller of a RAM-based FIFO. The FIFO storage is a window of addresses, from `win_lo` to `win_hi` inclusive, inside a larger RAM. Several controllers can therefore split one physical memory, and the window size does not have to be a power of two. A producer sends words over a valid/ready handshake. The controller turns each accepted word into a RAM write strobe, a write address and write data. It also reports to the producer how many window slots are occupied.

The read-side controller supplies the address it will read next on `rd_ptr`. In return it sees `commit_ptr`, the boundary up to which it may read. An external arbiter can stall every write through `arb_en`. This covers both sharing a memory between controllers and sharing a single-port RAM between the two sides of one FIFO.

With `COMMIT_EN` set, writes are speculative. The working pointer advances on every write. `commit_ptr` moves only when the producer commits, and an abort throws away everything written since the last commit. With `COMMIT_EN` clear, every write is visible to the reader at once.

Back-pressure rules: a word transfers on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` depends on `arb_en`, on `rd_ptr`, on `in_abort` (commit mode only) and on internal state. It never depends on `in_valid`. The producer may hold `in_valid` high for as long as it likes while `in_ready` is low.

Top module: `win_fifo_writer`

## Requirements
- R1: While `rst` is high at a clock edge, the working pointer and `commit_ptr` are both loaded with `win_lo`. With `rd_ptr` equal to `win_lo`, `usage` then reads 0.
- R2: `ram_we` is high exactly in cycles where `in_valid` and `in_ready` are both high. In such a cycle `ram_waddr` is the working pointer and `ram_wdata` equals `in_data`. After each write the working pointer moves to the next window slot.
- R3: The working pointer wraps from `win_hi` to `win_lo`. `ram_waddr` never leaves the window.
- R4: One slot is always kept empty. `in_ready` is low whenever the slot after the working pointer equals `rd_ptr`, so at most `win_hi - win_lo` entries are held.
- R5: While `arb_en` is low, `in_ready` and `ram_we` are low and the working pointer holds its value.
- R6: `usage` is ADDR_W+1 bits wide and equals (working pointer - `rd_ptr`) modulo the window size (`win_hi - win_lo + 1`). Uncommitted entries are included.
- R7: With `COMMIT_EN`=1, `commit_ptr` changes only after a cycle with `in_commit` high. It then takes the working pointer's value after that cycle, including any write accepted in the same cycle.
- R8: With `COMMIT_EN`=1, a cycle with `in_abort` high forces `in_ready` low and rewinds the working pointer to `commit_ptr`. Abort takes priority over a simultaneous commit, and `commit_ptr` is kept.
- R9: With `COMMIT_EN`=0, `commit_ptr` equals the working pointer in every cycle, and `in_commit` and `in_abort` have no effect.
- R10: The reader, reading from `rd_ptr` up to `commit_ptr`, gets the committed words in write order. Aborted words never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| arb_en | input | 1 | Arbitration grant; low stalls all writes |
| win_lo | input | ADDR_W | First address of the FIFO window |
| win_hi | input | ADDR_W | Last address of the FIFO window |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Controller can take a word this cycle |
| in_data | input | DATA_W | Producer word |
| in_commit | input | 1 | Publish all words written so far (commit mode) |
| in_abort | input | 1 | Discard uncommitted words (commit mode) |
| rd_ptr | input | ADDR_W | Next address the read side will consume |
| ram_we | output | 1 | RAM write strobe |
| ram_waddr | output | ADDR_W | RAM write address |
| ram_wdata | output | DATA_W | RAM write data |
| commit_ptr | output | ADDR_W | Write boundary visible to the read side |
| usage | output | ADDR_W+1 | Occupied slots seen by the producer |

## Verification
The commit-mode instance works in a window from 3 to 9. It sees bursts that are left uncommitted, a commit on its own, and a commit in the same cycle as a write, which shows whether the published boundary includes that write. It also sees aborts after partial bursts, and an abort coinciding with a commit, which shows the priority between them. Filling until `in_ready` drops and then draining sets the one-slot full rule apart from an off-by-one. A second round that crosses `win_hi` exposes a pointer that wraps at a binary boundary instead of at the window edge. Stretches with `arb_en` low, and a plain-mode instance in a window from 0 to 4 that receives commit and abort pulses, show that a stall or an ignored control really leaves the pointers untouched.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

  // Action applied to the working write pointer in one cycle.
  typedef enum logic [1:0] {
    PTR_HOLD   = 2'd0,
    PTR_STEP   = 2'd1,
    PTR_REWIND = 2'd2
  } ptr_op_e;

endpackage

// File: rtl/fwc_stepper.sv
// Next slot inside an arbitrary address window: wraps at the window top,
// not at a binary boundary.
module fwc_stepper #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  output logic [ADDR_W-1:0] nxt
);

  always_comb begin
    if (cur == hi) nxt = lo;
    else           nxt = cur + 1'b1;
  end

endmodule

// File: rtl/fwc_occupancy.sv
// Occupancy and full detection, using the keep-one-slot-empty rule.
module fwc_occupancy #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] wr_ptr,
  input  logic [ADDR_W-1:0] wr_step,
  input  logic [ADDR_W-1:0] rd_ptr,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  output logic              full,
  output logic [ADDR_W:0]   used
);

  localparam int CNT_W = ADDR_W + 1;

  logic [CNT_W-1:0] span;
  logic [CNT_W-1:0] wr_x;
  logic [CNT_W-1:0] rd_x;

  assign span = {1'b0, hi} - {1'b0, lo} + CNT_W'(1);
  assign wr_x = {1'b0, wr_ptr};
  assign rd_x = {1'b0, rd_ptr};

  always_comb begin
    if (wr_x >= rd_x) used = wr_x - rd_x;
    else              used = span - (rd_x - wr_x);
  end

  assign full = (wr_step == rd_ptr);

endmodule

// File: rtl/fwc_ptr_bank.sv
// Working and committed pointers; COMMIT_EN picks the speculative variant.
module fwc_ptr_bank
  import fwc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter bit COMMIT_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lo,
  input  logic              accept,
  input  logic [ADDR_W-1:0] step_ptr,
  input  logic              commit,
  input  logic              abort,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic [ADDR_W-1:0] com_ptr
);

  generate
    if (COMMIT_EN) begin : g_spec
      ptr_op_e           op;
      logic [ADDR_W-1:0] cur_q, com_q;
      logic [ADDR_W-1:0] cur_after;

      always_comb begin
        if (abort)       op = PTR_REWIND;
        else if (accept) op = PTR_STEP;
        else             op = PTR_HOLD;
      end

      always_comb begin
        unique case (op)
          PTR_STEP:   cur_after = step_ptr;
          PTR_REWIND: cur_after = com_q;
          default:    cur_after = cur_q;
        endcase
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          cur_q <= lo;
          com_q <= lo;
        end else begin
          cur_q <= cur_after;
          // abort wins: the committed boundary stays where it was
          if (commit && !abort) com_q <= cur_after;
        end
      end

      assign cur_ptr = cur_q;
      assign com_ptr = com_q;
    end else begin : g_direct
      logic [ADDR_W-1:0] cur_q;
      logic              ctl_unused;

      assign ctl_unused = commit ^ abort;

      always_ff @(posedge clk) begin
        if (rst)         cur_q <= lo;
        else if (accept) cur_q <= step_ptr;
      end

      assign cur_ptr = cur_q;
      assign com_ptr = cur_q;
    end
  endgenerate

endmodule

// File: rtl/win_fifo_writer.sv
module win_fifo_writer #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter bit COMMIT_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arb_en,
  input  logic [ADDR_W-1:0] win_lo,
  input  logic [ADDR_W-1:0] win_hi,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_commit,
  input  logic              in_abort,
  input  logic [ADDR_W-1:0] rd_ptr,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [ADDR_W-1:0] commit_ptr,
  output logic [ADDR_W:0]   usage
);

  logic [ADDR_W-1:0] cur_ptr;
  logic [ADDR_W-1:0] step_ptr;
  logic              full;
  logic              abort_blk;
  logic              accept;

  fwc_stepper #(.ADDR_W(ADDR_W)) u_step (
    .cur (cur_ptr),
    .lo  (win_lo),
    .hi  (win_hi),
    .nxt (step_ptr)
  );

  fwc_occupancy #(.ADDR_W(ADDR_W)) u_occ (
    .wr_ptr  (cur_ptr),
    .wr_step (step_ptr),
    .rd_ptr  (rd_ptr),
    .lo      (win_lo),
    .hi      (win_hi),
    .full    (full),
    .used    (usage)
  );

  // In commit mode an abort cycle takes no data, so nothing is silently lost.
  assign abort_blk = COMMIT_EN && in_abort;
  assign in_ready  = arb_en && !full && !abort_blk;
  assign accept    = in_valid && in_ready;

  fwc_ptr_bank #(.ADDR_W(ADDR_W), .COMMIT_EN(COMMIT_EN)) u_ptrs (
    .clk      (clk),
    .rst      (rst),
    .lo       (win_lo),
    .accept   (accept),
    .step_ptr (step_ptr),
    .commit   (in_commit),
    .abort    (in_abort),
    .cur_ptr  (cur_ptr),
    .com_ptr  (commit_ptr)
  );

  assign ram_we    = accept;
  assign ram_waddr = cur_ptr;
  assign ram_wdata = in_data;

endmodule

// File: rtl/fwc_checks.sv
module fwc_checks #(
  parameter int ADDR_W    = 8,
  parameter bit COMMIT_EN = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              arb_en,
  input logic [ADDR_W-1:0] win_lo,
  input logic [ADDR_W-1:0] win_hi,
  input logic              in_commit,
  input logic              in_abort,
  input logic              in_ready,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_waddr,
  input logic [ADDR_W-1:0] commit_ptr,
  input logic [ADDR_W:0]   usage
);

  p_stall_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    !arb_en |-> (!in_ready && !ram_we));

  p_addr_in_window_r3: assert property (@(posedge clk) disable iff (rst)
    (ram_waddr >= win_lo) && (ram_waddr <= win_hi));

  p_usage_cap_r4: assert property (@(posedge clk) disable iff (rst)
    usage <= ({1'b0, win_hi} - {1'b0, win_lo}));

  p_ptr_advance_r2: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> (ram_waddr == (($past(ram_waddr) == $past(win_hi)) ?
                              $past(win_lo) : ADDR_W'($past(ram_waddr) + 1'b1))));

  p_ptr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!ram_we && !in_abort) |=> $stable(ram_waddr));

  generate
    if (COMMIT_EN) begin : g_commit_props
      p_commit_only_r7: assert property (@(posedge clk) disable iff (rst)
        !in_commit |=> $stable(commit_ptr));

      p_abort_rewind_r8: assert property (@(posedge clk) disable iff (rst)
        in_abort |=> ((ram_waddr == $past(commit_ptr)) && $stable(commit_ptr)));
    end
  endgenerate

endmodule

bind win_fifo_writer fwc_checks #(.ADDR_W(ADDR_W), .COMMIT_EN(COMMIT_EN)) u_fwc_checks (
  .clk        (clk),
  .rst        (rst),
  .arb_en     (arb_en),
  .win_lo     (win_lo),
  .win_hi     (win_hi),
  .in_commit  (in_commit),
  .in_abort   (in_abort),
  .in_ready   (in_ready),
  .ram_we     (ram_we),
  .ram_waddr  (ram_waddr),
  .commit_ptr (commit_ptr),
  .usage      (usage)
);

// File: tb/win_fifo_writer_bench.sv
module win_fifo_writer_bench;

  localparam int DW = 8;
  localparam int AW = 4;
  localparam logic [AW-1:0] LO  = 4'd3;
  localparam logic [AW-1:0] HI  = 4'd9;
  localparam logic [AW-1:0] PLO = 4'd0;
  localparam logic [AW-1:0] PHI = 4'd4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  int n_chk = 0;
  int n_bad = 0;

  // ---- commit-mode instance ----
  logic          arb_en = 1'b0, in_valid = 1'b0, in_commit = 1'b0, in_abort = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [AW-1:0] rd_ptr = LO;
  logic          in_ready, ram_we;
  logic [AW-1:0] ram_waddr, commit_ptr;
  logic [DW-1:0] ram_wdata;
  logic [AW:0]   usage;

  win_fifo_writer #(.DATA_W(DW), .ADDR_W(AW), .COMMIT_EN(1'b1)) u_win_fifo_writer (
    .clk(clk), .rst(rst), .arb_en(arb_en), .win_lo(LO), .win_hi(HI),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_commit(in_commit), .in_abort(in_abort), .rd_ptr(rd_ptr),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .commit_ptr(commit_ptr), .usage(usage)
  );

  // ---- plain-mode instance ----
  logic          p_valid = 1'b0, p_commit = 1'b0, p_abort = 1'b0;
  logic [DW-1:0] p_data = '0;
  logic          p_ready, p_we;
  logic [AW-1:0] p_waddr, p_cptr;
  logic [DW-1:0] p_wdata;
  logic [AW:0]   p_usage;

  win_fifo_writer #(.DATA_W(DW), .ADDR_W(AW), .COMMIT_EN(1'b0)) u_win_fifo_writer_plain (
    .clk(clk), .rst(rst), .arb_en(1'b1), .win_lo(PLO), .win_hi(PHI),
    .in_valid(p_valid), .in_ready(p_ready), .in_data(p_data),
    .in_commit(p_commit), .in_abort(p_abort), .rd_ptr(PLO),
    .ram_we(p_we), .ram_waddr(p_waddr), .ram_wdata(p_wdata),
    .commit_ptr(p_cptr), .usage(p_usage)
  );

  // behavioural RAM shared by the window
  logic [DW-1:0] ram_m [16];
  always_ff @(posedge clk) if (ram_we) ram_m[ram_waddr] <= ram_wdata;

  // requirement-level model
  logic [AW-1:0] cur_m = LO, com_m = LO, rd_m = LO;
  logic [DW-1:0] pend_q[$];
  logic [DW-1:0] exp_q[$];
  logic [AW-1:0] pcur_m = PLO;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p, input logic [AW-1:0] lo,
                                        input logic [AW-1:0] hi);
    return (p == hi) ? lo : AW'(p + 1'b1);
  endfunction

  function automatic int used_m();
    return (cur_m >= rd_m) ? int'(cur_m) - int'(rd_m) : int'(cur_m) + 7 - int'(rd_m);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // one cycle on the commit-mode instance: driver + monitor
  task automatic cyc(input bit v, input logic [DW-1:0] d, input bit cm, input bit ab,
                     input bit en, input bit rden);
    bit acc, rdy_e;
    logic [AW-1:0] cur_n;
    @(negedge clk);
    in_valid = v; in_data = d; in_commit = cm; in_abort = ab; arb_en = en;
    #1;
    rdy_e = en && (nxt(cur_m, LO, HI) != rd_m) && !ab;
    if (!en)                            check(in_ready == 1'b0, "R5 ready", int'(in_ready), 0);
    else if (ab)                        check(in_ready == 1'b0, "R8 ready", int'(in_ready), 0);
    else                                check(in_ready == rdy_e, "R4 ready", int'(in_ready), int'(rdy_e));
    acc = v && rdy_e;
    check(ram_we == acc, "R2 we", int'(ram_we), int'(acc));
    check(ram_waddr == cur_m, "R3 waddr", int'(ram_waddr), int'(cur_m));
    check(commit_ptr == com_m, "R7 commit_ptr", int'(commit_ptr), int'(com_m));
    check(int'(usage) == used_m(), "R6 usage", int'(usage), used_m());
    if (acc) begin
      check(ram_wdata == d, "R2 wdata", int'(ram_wdata), int'(d));
      pend_q.push_back(d);
    end
    // monitor: consume one committed word
    if (rden && rd_m != com_m) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected word", int'(ram_m[rd_m]), -1);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(ram_m[rd_m] == e, "R10 order", int'(ram_m[rd_m]), int'(e));
      end
      rd_m = nxt(rd_m, LO, HI);
    end
    cur_n = acc ? nxt(cur_m, LO, HI) : cur_m;
    if (ab) begin
      cur_m = com_m;
      pend_q.delete();
    end else begin
      cur_m = cur_n;
      if (cm) begin
        com_m = cur_n;
        while (pend_q.size() > 0) exp_q.push_back(pend_q.pop_front());
      end
    end
    @(posedge clk);
    #1 rd_ptr = rd_m;
  endtask

  // one cycle on the plain-mode instance
  task automatic pcyc(input bit v, input logic [DW-1:0] d, input bit cm, input bit ab);
    bit rdy_e;
    @(negedge clk);
    p_valid = v; p_data = d; p_commit = cm; p_abort = ab;
    #1;
    rdy_e = (nxt(pcur_m, PLO, PHI) != PLO);
    check(p_ready == rdy_e, "R4 plain ready", int'(p_ready), int'(rdy_e));
    check(p_cptr == pcur_m, "R9 plain commit_ptr", int'(p_cptr), int'(pcur_m));
    check(p_waddr == pcur_m, "R9 plain waddr", int'(p_waddr), int'(pcur_m));
    if (v && rdy_e) pcur_m = nxt(pcur_m, PLO, PHI);
    @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(ram_waddr == LO, "R1 waddr", int'(ram_waddr), int'(LO));
    check(commit_ptr == LO, "R1 commit_ptr", int'(commit_ptr), int'(LO));
    check(usage == 0, "R1 usage", int'(usage), 0);
    rst = 1'b0;

    // uncommitted burst: reader sees nothing (R7), usage counts it (R6)
    cyc(1, 8'h11, 0, 0, 1, 1);
    cyc(1, 8'h22, 0, 0, 1, 1);
    cyc(1, 8'h33, 0, 0, 1, 1);
    cyc(0, 8'h00, 0, 0, 1, 1);
    // lone commit
    cyc(0, 8'h00, 1, 0, 1, 0);
    // write + commit in same cycle includes that write (R7)
    cyc(1, 8'h44, 0, 0, 1, 0);
    cyc(1, 8'h55, 1, 0, 1, 0);
    // partial burst then abort (R8)
    cyc(1, 8'hA1, 0, 0, 1, 0);
    cyc(1, 8'hA2, 0, 0, 1, 0);
    cyc(1, 8'hA3, 0, 0, 1, 0);
    cyc(1, 8'hA4, 0, 1, 1, 0);
    cyc(0, 8'h00, 0, 0, 1, 0);
    // abort together with commit: abort wins (R8)
    cyc(1, 8'hB1, 0, 0, 1, 0);
    cyc(1, 8'hB2, 1, 1, 1, 0);
    // stall by arbiter (R5)
    cyc(1, 8'hC1, 0, 0, 0, 0);
    cyc(1, 8'hC2, 0, 0, 0, 0);
    // fill to full (R4), commit
    for (int i = 0; i < 4; i++) cyc(1, 8'(8'h60 + i), 0, 0, 1, 0);
    cyc(0, 8'h00, 1, 0, 1, 0);
    // drain everything (R10)
    for (int i = 0; i < 8; i++) cyc(0, 8'h00, 0, 0, 1, 1);
    // second round crossing the window top (R3), reading concurrently
    for (int i = 0; i < 10; i++) cyc(1, 8'(8'h70 + i), (i % 3) == 2, 0, 1, (i % 2) == 1);
    cyc(0, 8'h00, 1, 0, 1, 1);
    for (int i = 0; i < 8; i++) cyc(0, 8'h00, 0, 0, 1, 1);
    check(exp_q.size() == 0, "R10 drained", exp_q.size(), 0);
    check(ram_waddr == rd_ptr, "R6 empty after drain", int'(ram_waddr), int'(rd_ptr));

    // plain mode: commit/abort ignored, fills to 4 of 5 slots (R9, R4)
    pcyc(1, 8'h01, 0, 1);
    pcyc(1, 8'h02, 1, 0);
    pcyc(1, 8'h03, 0, 1);
    pcyc(1, 8'h04, 1, 1);
    pcyc(1, 8'h05, 0, 1);
    pcyc(0, 8'h00, 0, 0);
    @(negedge clk);
    check(p_usage == 5'd4, "R9 plain usage", int'(p_usage), 4);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule